// File: doc/BRIEF.md
# Retransmit-Once Reassembly Slot Controller

This block sits at the receiving end of a bufferless on-chip network and manages a small pool of reassembly slots. A sender transmits each packet without asking first. When the head flit of a packet arrives, the controller admits it into a slot if one is available. If no slot is available, it discards the packet and records the packet's tag (source node and request ID) in a pending queue. Any later body flit that does not belong to a held slot is discarded.

When a slot frees up and a drop is waiting, the controller reserves that slot for the oldest recorded tag. It then raises a retransmit request to that sender over a valid/ready handshake. The retransmitted head flit always finds its reserved slot, so each dropped packet is resent exactly once. An admitted slot stays held until the requester releases it, which lets the slot span the request, response and writeback of one transaction.

Top module: `rtx_once_reasm`

## Requirements
- R1: After reset every slot is free, the pending queue is empty and `rtx_valid` is low.
- R2: A head flit whose tag matches no reserved slot is admitted when the pending queue is empty and a slot is free. It takes the lowest-numbered free slot, and that index appears on `flit_slot` in the same cycle as `flit_accept`.
- R3: A head flit that cannot be admitted under R2 or R7 is discarded (`flit_accept` low). Its tag is appended to the pending queue unless that tag is already queued. A push into a full queue is an error.
- R4: A body flit (`flit_head` low) is accepted only if its tag matches a held slot, and it reports that slot's index. All other body flits are discarded.
- R5: When the pending queue is non-empty, a slot is free and no retransmit request is outstanding, the lowest free slot is reserved for the oldest pending tag. From the next cycle `rtx_valid` is high with that tag on `rtx_src`/`rtx_req`. The request stays stable until a cycle with `rtx_ready` high, and it drops in the cycle after that.
- R6: Pending tags are reserved and requested in the order they were dropped.
- R7: A head flit whose tag matches a reserved slot is admitted into that slot, even while other drops are pending. The slot is held from the next cycle.
- R8: A release naming a held slot frees it from the next cycle. A release naming a free or reserved slot has no effect.
- R9: A reserved slot is never given to a head flit carrying another tag. Such a head takes another free slot or is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flit_valid | input | 1 | A flit is presented this cycle |
| flit_head | input | 1 | The flit is the first flit of its packet |
| flit_src | input | SRC_W | Sender node of the flit |
| flit_req | input | REQ_W | Request ID of the flit |
| flit_accept | output | 1 | The flit is taken into a slot (combinational) |
| flit_slot | output | SLOT_W | Slot index for an accepted flit, zero otherwise |
| release_valid | input | 1 | The requester releases a slot |
| release_slot | input | SLOT_W | Index of the slot being released |
| rtx_valid | output | 1 | A retransmit request is pending |
| rtx_ready | input | 1 | The retransmit request is taken this cycle |
| rtx_src | output | SRC_W | Sender that must retransmit |
| rtx_req | output | REQ_W | Request ID to retransmit |

## Verification
Most internal state is visible only later, so the bench tracks slot states and the pending order in a behavioural model and compares every output on every cycle. A slot freed too early or not at all changes which index the next admitted head receives. It also changes when `rtx_valid` next rises, and both differences appear within one or two cycles. A lost or reordered pending tag appears as a wrong tag on `rtx_src`/`rtx_req` the first time that entry reaches the head of the queue. A reservation that is not kept appears when the matching retransmitted head is dropped instead of accepted.

// File: rtl/rtx_once_reasm.sv
module rtx_once_reasm #(
  parameter int NSLOT      = 4,
  parameter int PEND_DEPTH = 4,
  parameter int SRC_W      = 4,
  parameter int REQ_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flit_valid,
  input  logic              flit_head,
  input  logic [SRC_W-1:0]  flit_src,
  input  logic [REQ_W-1:0]  flit_req,
  output logic              flit_accept,
  output logic [$clog2(NSLOT)-1:0] flit_slot,
  input  logic              release_valid,
  input  logic [$clog2(NSLOT)-1:0] release_slot,
  output logic              rtx_valid,
  input  logic              rtx_ready,
  output logic [SRC_W-1:0]  rtx_src,
  output logic [REQ_W-1:0]  rtx_req
);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int TAG_W  = SRC_W + REQ_W;
  localparam int PTR_W  = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;
  localparam logic [1:0] S_FREE = 2'd0, S_RSVD = 2'd1, S_BUSY = 2'd2;

  logic [1:0]       st_q   [NSLOT];
  logic [TAG_W-1:0] stag_q [NSLOT];
  logic [TAG_W-1:0] ptag_q [PEND_DEPTH];
  logic             pv_q   [PEND_DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [TAG_W-1:0] rtag_q;

  wire [TAG_W-1:0] tag   = {flit_src, flit_req};
  wire             empty = !pv_q[rd_q];
  wire             full  = pv_q[wr_q];

  logic rs_hit, bz_hit, fr_hit, dup;
  logic [SLOT_W-1:0] rs_idx, bz_idx, fr_idx;

  always_comb begin
    rs_hit = 1'b0; bz_hit = 1'b0; fr_hit = 1'b0; dup = 1'b0;
    rs_idx = '0;   bz_idx = '0;   fr_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (st_q[i] == S_FREE) begin
        fr_hit = 1'b1; fr_idx = SLOT_W'(i);
      end
      if (st_q[i] == S_RSVD && stag_q[i] == tag) begin
        rs_hit = 1'b1; rs_idx = SLOT_W'(i);
      end
      if (st_q[i] == S_BUSY && stag_q[i] == tag) begin
        bz_hit = 1'b1; bz_idx = SLOT_W'(i);
      end
    end
    for (int k = 0; k < PEND_DEPTH; k++)
      if (pv_q[k] && ptag_q[k] == tag) dup = 1'b1;
  end

  wire head      = flit_valid && flit_head;
  wire take_rs   = head && rs_hit;
  wire take_fr   = head && !rs_hit && empty && fr_hit;
  wire take_body = flit_valid && !flit_head && bz_hit;
  wire push_want = head && !rs_hit && !(empty && fr_hit) && !dup;
  wire push      = push_want && !full;
  wire reserve   = !empty && fr_hit && !rtx_valid;

  assign flit_accept = take_rs || take_fr || take_body;
  assign flit_slot   = take_rs ? rs_idx : take_fr ? fr_idx : take_body ? bz_idx : '0;
  assign {rtx_src, rtx_req} = rtag_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(PEND_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        st_q[i] <= S_FREE; stag_q[i] <= '0;
      end
      for (int k = 0; k < PEND_DEPTH; k++) begin
        pv_q[k] <= 1'b0; ptag_q[k] <= '0;
      end
      rd_q <= '0; wr_q <= '0;
      rtx_valid <= 1'b0; rtag_q <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (release_valid && release_slot == SLOT_W'(i) && st_q[i] == S_BUSY)
          st_q[i] <= S_FREE;
        if (reserve && fr_idx == SLOT_W'(i)) begin
          st_q[i] <= S_RSVD; stag_q[i] <= ptag_q[rd_q];
        end
        if ((take_rs || take_fr) && flit_slot == SLOT_W'(i)) begin
          st_q[i] <= S_BUSY; stag_q[i] <= tag;
        end
      end
      if (reserve) begin
        pv_q[rd_q] <= 1'b0; rd_q <= nxt(rd_q);
        rtx_valid <= 1'b1;  rtag_q <= ptag_q[rd_q];
      end else if (rtx_ready) begin
        rtx_valid <= 1'b0;
      end
      if (push) begin
        pv_q[wr_q] <= 1'b1; ptag_q[wr_q] <= tag; wr_q <= nxt(wr_q);
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !rtx_valid);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_want && full));
  // R5
  rtx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtx_valid && !rtx_ready |=> rtx_valid && $stable(rtx_src) && $stable(rtx_req));
  // R7
  admit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && flit_head && flit_accept |=> st_q[$past(flit_slot)] == S_BUSY);
  // R8
  release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_valid && st_q[release_slot] == S_BUSY |=> st_q[$past(release_slot)] == S_FREE);
endmodule

// File: tb/rtx_once_reasm_bench.sv
module rtx_once_reasm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FREE = 0, RSVD = 1, BUSY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flit_valid = 0, flit_head = 0, release_valid = 0, rtx_ready = 0;
  logic [3:0] flit_src = 0, flit_req = 0;
  logic [1:0] release_slot = 0;
  logic flit_accept, rtx_valid;
  logic [1:0] flit_slot;
  logic [3:0] rtx_src, rtx_req;

  rtx_once_reasm u_rtx_once_reasm (
    .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
    .flit_src(flit_src), .flit_req(flit_req), .flit_accept(flit_accept),
    .flit_slot(flit_slot), .release_valid(release_valid), .release_slot(release_slot),
    .rtx_valid(rtx_valid), .rtx_ready(rtx_ready), .rtx_src(rtx_src), .rtx_req(rtx_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  string cur = "R1";
  int mst[4];
  logic [7:0] mtag[4];
  logic [7:0] mpend[$];
  bit mrv = 0;
  logic [7:0] mrt = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; tests++;
      $display("FAIL watchdog expired (all reqs): got running, expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input bit fv, input bit fh, input int s, input int r,
                      input bit rv, input int rs, input bit rdy);
    logic [7:0] t;
    bit e_acc, res, pend_has, rs_hit, fr_hit;
    int e_slot, rslot, frs;
    flit_valid = fv; flit_head = fh; flit_src = s[3:0]; flit_req = r[3:0];
    release_valid = rv; release_slot = rs[1:0]; rtx_ready = rdy;
    t = {s[3:0], r[3:0]};
    #1;
    e_acc = 0; e_slot = 0; rs_hit = 0; fr_hit = 0; frs = 0;
    for (int i = 3; i >= 0; i--) if (mst[i] == FREE) begin fr_hit = 1; frs = i; end
    pend_has = 0;
    foreach (mpend[k]) if (mpend[k] == t) pend_has = 1;
    if (fv && fh) begin
      for (int i = 0; i < 4; i++)
        if (!rs_hit && mst[i] == RSVD && mtag[i] == t) begin rs_hit = 1; e_slot = i; end
      if (rs_hit) e_acc = 1;
      else if (mpend.size() == 0 && fr_hit) begin e_acc = 1; e_slot = frs; end
    end else if (fv) begin
      for (int i = 0; i < 4; i++)
        if (!e_acc && mst[i] == BUSY && mtag[i] == t) begin e_acc = 1; e_slot = i; end
    end
    tests++;
    if (flit_accept !== e_acc || (e_acc && flit_slot !== e_slot[1:0])) begin
      fails++;
      $display("FAIL %s flit: got acc=%b slot=%0d, expected acc=%b slot=%0d",
               cur, flit_accept, flit_slot, e_acc, e_slot);
    end
    tests++;
    if (rtx_valid !== mrv || (mrv && {rtx_src, rtx_req} !== mrt)) begin
      fails++;
      $display("FAIL %s rtx: got v=%b tag=%h, expected v=%b tag=%h",
               cur, rtx_valid, {rtx_src, rtx_req}, mrv, mrt);
    end
    res = mpend.size() > 0 && fr_hit && !mrv;
    rslot = frs;
    @(posedge clk);
    if (rv && mst[rs] == BUSY) mst[rs] = FREE;
    if (res) begin
      mrv = 1; mrt = mpend.pop_front(); mst[rslot] = RSVD; mtag[rslot] = mrt;
    end else if (mrv && rdy) mrv = 0;
    if (e_acc && fh) begin mst[e_slot] = BUSY; mtag[e_slot] = t; end
    if (fv && fh && !e_acc && !pend_has) mpend.push_back(t);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, rdy);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mst[i] = FREE; mtag[i] = 0; end
    @(negedge clk); @(negedge clk);
    cur = "R1"; tests++;
    if (rtx_valid !== 1'b0 || flit_accept !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got rtx=%b acc=%b, expected 0 0", rtx_valid, flit_accept);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle(1, 0);
    cur = "R2";
    for (int i = 1; i <= 4; i++) step(1, 1, i, 1, 0, 0, 0);
    cur = "R4";
    step(1, 0, 2, 1, 0, 0, 0);
    step(1, 0, 12, 1, 0, 0, 0);
    cur = "R3";
    step(1, 1, 5, 2, 0, 0, 0);
    cur = "R4";
    step(1, 0, 5, 2, 0, 0, 0);
    cur = "R3";
    step(1, 1, 5, 2, 0, 0, 0);
    cur = "R8";
    step(0, 0, 0, 0, 1, 2, 0);
    cur = "R5";
    idle(4, 0);
    cur = "R8";
    step(0, 0, 0, 0, 1, 2, 0);
    step(0, 0, 0, 0, 1, 3, 0);
    cur = "R9";
    step(1, 1, 9, 9, 0, 0, 0);
    cur = "R5";
    idle(1, 1);
    cur = "R7";
    step(1, 1, 5, 2, 0, 0, 1);
    cur = "R4";
    step(1, 0, 5, 2, 0, 0, 1);
    cur = "R3";
    step(1, 1, 6, 3, 0, 0, 1);
    step(1, 1, 7, 4, 0, 0, 1);
    cur = "R8";
    step(0, 0, 0, 0, 1, 0, 1);
    cur = "R3";
    step(1, 1, 8, 8, 0, 0, 1);
    cur = "R6";
    idle(2, 1);
    step(0, 0, 0, 0, 1, 1, 1);
    idle(3, 1);
    step(0, 0, 0, 0, 1, 3, 1);
    idle(3, 1);
    cur = "R7";
    step(1, 1, 6, 3, 0, 0, 1);
    step(1, 1, 8, 8, 0, 0, 1);
    step(1, 1, 7, 4, 0, 0, 1);
    cur = "R8";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, i, 1);
    step(0, 0, 0, 0, 1, 0, 1);
    cur = "R2";
    step(1, 1, 10, 1, 0, 0, 1);
    step(1, 1, 11, 1, 0, 0, 1);
    idle(2, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule